// File: doc/BRIEF.md
# Word-Level Control Symbol Splicer for a Serial Link

This block sits in a serial link transmitter and merges short link control symbols into the outgoing packet word stream. A symbol waiting to be sent can take the very next output slot, even in the middle of a packet. It does not wait for the packet to end. This keeps flow-control updates, time or frame ticks and congestion notices moving with a small, fixed delay while long packets are on the wire.

There are three symbol classes, each with its own request lane. The first is a periodic event tick. The second reports how many receive buffers are free, so the peer can resume as soon as one frees up. The third is a congestion notice that tells upstream senders which destinations are blocked. When several lanes request at once, the event tick goes first, then buffer status, then congestion. Each output word carries a tag bit that marks it as a symbol.

A mode input selects a comparison behaviour in which symbols are held back until the open packet has finished. The same top also contains the receive-side extractor. It steers tagged words to a symbol output and removes them from the packet stream, so the packet words arrive with their original start and end markers. The transmit link output and the receive link input are separate ports, so the two halves can be looped back or placed on opposite ends of a link.

Top module: `csym_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released with idle inputs, `link_valid`, `rx_pkt_valid` and `rx_sym_valid` are low and `pkt_ready` is high.
- R2: A packet word accepted in a cycle (`pkt_valid` and `pkt_ready` both high) appears on the link in the next cycle with `link_tag`=0, its data unchanged, and its start and end flags preserved.
- R3: A symbol request with no higher-priority request pending is accepted in the same cycle (`sym_ready` bit set). It appears on the link in the next cycle with `link_tag`=1, the payload in bits [SW-1:0], the class code in bits [SW+1:SW] and the remaining bits zero. The class code equals the index of the request lane: 0 = event tick, 1 = buffer status, 2 = congestion.
- R4: Concurrent symbol requests are served one per cycle, lowest class code first. Requests that are not served see `sym_ready` low and stay pending.
- R5: In immediate mode (`hold_mode`=0), a symbol accepted while a packet is open deasserts `pkt_ready` for exactly that cycle. The packet word presented in that cycle is sent in the following cycle, and no packet word is dropped or reordered.
- R6: Symbols requested in consecutive cycles each take one output slot. The packet stalls for one cycle per symbol.
- R7: In hold mode (`hold_mode`=1), no symbol is accepted from the cycle after a start word is accepted until the cycle in which its end word is accepted. The pending symbol is accepted in the next cycle and follows the end word directly on the link.
- R8: In hold mode with no packet open, a symbol request still wins over a start word presented in the same cycle: `pkt_ready` is low and the symbol is sent in the next cycle.
- R9: A link input word with `rx_tag`=1 appears one cycle later on the symbol output, with the class code and payload from the positions given in R3, and produces no packet output.
- R10: The packet output of the extractor reproduces the transmitted packet words in order, with matching start and end flags. A start flag is never seen on the packet output while a packet is still open there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_mode | input | 1 | 1 = hold symbols until the open packet ends; 0 = insert at word granularity |
| pkt_valid | input | 1 | Packet word present |
| pkt_sop | input | 1 | Packet word is the first of its packet |
| pkt_eop | input | 1 | Packet word is the last of its packet |
| pkt_data | input | 32 | Packet word data |
| pkt_ready | output | 1 | Packet word accepted this cycle when high |
| sym_valid | input | 3 | Symbol request per class (bit index = class code) |
| sym_data | input | 3x16 | Symbol payload per class |
| sym_ready | output | 3 | Symbol request accepted this cycle, one bit per class |
| link_valid | output | 1 | Transmit link word present |
| link_tag | output | 1 | Transmit link word is a control symbol |
| link_sop | output | 1 | Transmit link word starts a packet |
| link_eop | output | 1 | Transmit link word ends a packet |
| link_data | output | 32 | Transmit link word data |
| rx_valid | input | 1 | Receive link word present |
| rx_tag | input | 1 | Receive link word is a control symbol |
| rx_sop | input | 1 | Receive link word starts a packet |
| rx_eop | input | 1 | Receive link word ends a packet |
| rx_data | input | 32 | Receive link word data |
| rx_pkt_valid | output | 1 | Reassembled packet word present |
| rx_pkt_sop | output | 1 | Reassembled packet word starts a packet |
| rx_pkt_eop | output | 1 | Reassembled packet word ends a packet |
| rx_pkt_data | output | 32 | Reassembled packet word data |
| rx_sym_valid | output | 1 | Extracted symbol present |
| rx_sym_cls | output | 2 | Extracted symbol class code |
| rx_sym_data | output | 16 | Extracted symbol payload |

## Verification
The splicer is driven with several patterns:
- A bare packet with no symbols separates plain pass-through from any unwanted stall.
- A lone symbol on an idle link pins down the one-cycle request-to-link latency and the field encoding.
- All three classes raised together tell a correct priority order apart from any other order.
- A symbol injected in mid-packet, and a burst of three in a row, show whether the packet stalls for exactly one slot per symbol and resumes without losing a word.
- In hold mode, a request raised in mid-packet shows whether the symbol waits for the end word and then follows it directly, and a request that collides with a start word shows that a closed packet is not blocked.

Every pattern is looped back into the extractor, and its packet and symbol outputs are compared with queues of what was accepted.

// File: rtl/csym_pkg.sv
package csym_pkg;
  localparam int unsigned NUM_CLASSES = 3;
  localparam int unsigned CLS_W       = 2;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned PAYLOAD_W   = 16;

  // Class code equals request lane index and arbitration rank (0 wins).
  typedef enum logic [CLS_W-1:0] {
    CLS_EVENT   = 2'd0,
    CLS_BUFSTAT = 2'd1,
    CLS_CONGEST = 2'd2
  } sym_class_e;
endpackage

// File: rtl/csym_arbiter.sv
module csym_arbiter #(
  parameter int unsigned NCLS = 3
) (
  input  logic            allow,
  input  logic [NCLS-1:0] req,
  output logic [NCLS-1:0] gnt
);
  // above[i]: some lane with a lower index (higher rank) is requesting
  logic [NCLS-1:0] above;

  assign above[0] = 1'b0;

  for (genvar i = 0; i < NCLS; i++) begin : g_rank
    assign gnt[i] = allow & req[i] & ~above[i];
    if (i + 1 < NCLS) begin : g_chain
      assign above[i+1] = above[i] | req[i];
    end
  end
endmodule

// File: rtl/csym_inserter.sv
module csym_inserter #(
  parameter int unsigned DW   = 32,
  parameter int unsigned SW   = 16,
  parameter int unsigned NCLS = 3,
  parameter int unsigned CW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold_mode,
  input  logic                     pkt_valid,
  input  logic                     pkt_sop,
  input  logic                     pkt_eop,
  input  logic [DW-1:0]            pkt_data,
  output logic                     pkt_ready,
  input  logic [NCLS-1:0]          sym_valid,
  input  logic [NCLS-1:0][SW-1:0]  sym_data,
  output logic [NCLS-1:0]          sym_ready,
  output logic                     link_valid,
  output logic                     link_tag,
  output logic                     link_sop,
  output logic                     link_eop,
  output logic [DW-1:0]            link_data
);
  localparam int unsigned FIELD_W = SW + CW;

  logic [NCLS-1:0] gnt;
  logic            any_gnt, allow, pkt_fire, out_en;
  logic            in_pkt_q, in_pkt_d;
  logic [CW-1:0]   sel_cls;
  logic [SW-1:0]   sel_pay;
  logic [DW-1:0]   sym_word;
  logic            lv_d, tag_d, sop_d, eop_d;
  logic [DW-1:0]   data_d;
  logic            lk_open_q, lk_open_d;

  assign allow = ~hold_mode | ~in_pkt_q;

  csym_arbiter #(.NCLS(NCLS)) u_arb (
    .allow (allow),
    .req   (sym_valid),
    .gnt   (gnt)
  );

  assign any_gnt   = |gnt;
  assign sym_ready = gnt;
  assign pkt_ready = ~any_gnt;

  // next-state logic
  always_comb begin
    sel_cls = '0;
    sel_pay = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (gnt[i]) begin
        sel_cls = CW'(i);
        sel_pay = sym_data[i];
      end
    end
    sym_word                = '0;
    sym_word[FIELD_W-1:0]   = {sel_cls, sel_pay};

    pkt_fire = pkt_valid & ~any_gnt;
    in_pkt_d = in_pkt_q;
    if (pkt_fire) begin
      if (pkt_eop)      in_pkt_d = 1'b0;
      else if (pkt_sop) in_pkt_d = 1'b1;
    end

    out_en = pkt_fire | any_gnt;
    lv_d   = out_en;
    tag_d  = any_gnt;
    sop_d  = pkt_fire & pkt_sop;
    eop_d  = pkt_fire & pkt_eop;
    data_d = any_gnt ? sym_word : pkt_data;

    lk_open_d = lk_open_q;
    if (link_valid && !link_tag) begin
      if (link_eop)      lk_open_d = 1'b0;
      else if (link_sop) lk_open_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      link_valid <= 1'b0;
      link_tag   <= 1'b0;
      link_sop   <= 1'b0;
      link_eop   <= 1'b0;
      link_data  <= '0;
      lk_open_q  <= 1'b0;
    end else begin
      in_pkt_q   <= in_pkt_d;
      link_valid <= lv_d;
      link_tag   <= tag_d;
      link_sop   <= sop_d;
      link_eop   <= eop_d;
      if (out_en) link_data <= data_d;
      lk_open_q  <= lk_open_d;
    end
  end

  p_sym_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|sym_ready) |=> (link_valid && link_tag));

  p_pkt_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> (link_valid && !link_tag &&
      link_data == $past(pkt_data) && link_sop == $past(pkt_sop) &&
      link_eop == $past(pkt_eop)));

  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sym_ready));

  p_hold_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_mode) && lk_open_q && link_valid) |-> !link_tag);
endmodule

// File: rtl/csym_extractor.sv
module csym_extractor #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_tag,
  input  logic          rx_sop,
  input  logic          rx_eop,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pkt_valid,
  output logic          rx_pkt_sop,
  output logic          rx_pkt_eop,
  output logic [DW-1:0] rx_pkt_data,
  output logic          rx_sym_valid,
  output logic [CW-1:0] rx_sym_cls,
  output logic [SW-1:0] rx_sym_data
);
  logic pv_d, sv_d, open_q, open_d;

  // next-state logic
  always_comb begin
    pv_d   = rx_valid & ~rx_tag;
    sv_d   = rx_valid &  rx_tag;
    open_d = open_q;
    if (rx_pkt_valid) begin
      if (rx_pkt_eop)      open_d = 1'b0;
      else if (rx_pkt_sop) open_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pkt_valid <= 1'b0;
      rx_pkt_sop   <= 1'b0;
      rx_pkt_eop   <= 1'b0;
      rx_pkt_data  <= '0;
      rx_sym_valid <= 1'b0;
      rx_sym_cls   <= '0;
      rx_sym_data  <= '0;
      open_q       <= 1'b0;
    end else begin
      rx_pkt_valid <= pv_d;
      rx_sym_valid <= sv_d;
      open_q       <= open_d;
      if (pv_d) begin
        rx_pkt_sop  <= rx_sop;
        rx_pkt_eop  <= rx_eop;
        rx_pkt_data <= rx_data;
      end
      if (sv_d) begin
        rx_sym_cls  <= rx_data[SW+CW-1:SW];
        rx_sym_data <= rx_data[SW-1:0];
      end
    end
  end

  p_sym_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_tag) |=> (rx_sym_valid && !rx_pkt_valid &&
      rx_sym_data == $past(rx_data[SW-1:0])));

  p_pkt_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_tag) |=> (rx_pkt_valid && !rx_sym_valid &&
      rx_pkt_data == $past(rx_data)));

  p_splice_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_valid && rx_pkt_sop) |-> !open_q);
endmodule

// File: rtl/csym_link.sv
module csym_link
  import csym_pkg::*;
#(
  parameter int unsigned DW   = WORD_W,
  parameter int unsigned SW   = PAYLOAD_W,
  parameter int unsigned NCLS = NUM_CLASSES,
  parameter int unsigned CW   = CLS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold_mode,
  input  logic                     pkt_valid,
  input  logic                     pkt_sop,
  input  logic                     pkt_eop,
  input  logic [DW-1:0]            pkt_data,
  output logic                     pkt_ready,
  input  logic [NCLS-1:0]          sym_valid,
  input  logic [NCLS-1:0][SW-1:0]  sym_data,
  output logic [NCLS-1:0]          sym_ready,
  output logic                     link_valid,
  output logic                     link_tag,
  output logic                     link_sop,
  output logic                     link_eop,
  output logic [DW-1:0]            link_data,
  input  logic                     rx_valid,
  input  logic                     rx_tag,
  input  logic                     rx_sop,
  input  logic                     rx_eop,
  input  logic [DW-1:0]            rx_data,
  output logic                     rx_pkt_valid,
  output logic                     rx_pkt_sop,
  output logic                     rx_pkt_eop,
  output logic [DW-1:0]            rx_pkt_data,
  output logic                     rx_sym_valid,
  output logic [CW-1:0]            rx_sym_cls,
  output logic [SW-1:0]            rx_sym_data
);
  csym_inserter #(.DW(DW), .SW(SW), .NCLS(NCLS), .CW(CW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_mode  (hold_mode),
    .pkt_valid  (pkt_valid),
    .pkt_sop    (pkt_sop),
    .pkt_eop    (pkt_eop),
    .pkt_data   (pkt_data),
    .pkt_ready  (pkt_ready),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data),
    .sym_ready  (sym_ready),
    .link_valid (link_valid),
    .link_tag   (link_tag),
    .link_sop   (link_sop),
    .link_eop   (link_eop),
    .link_data  (link_data)
  );

  csym_extractor #(.DW(DW), .SW(SW), .CW(CW)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_tag       (rx_tag),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_data      (rx_data),
    .rx_pkt_valid (rx_pkt_valid),
    .rx_pkt_sop   (rx_pkt_sop),
    .rx_pkt_eop   (rx_pkt_eop),
    .rx_pkt_data  (rx_pkt_data),
    .rx_sym_valid (rx_sym_valid),
    .rx_sym_cls   (rx_sym_cls),
    .rx_sym_data  (rx_sym_data)
  );
endmodule

// File: tb/csym_link_test.sv
`timescale 1ns/1ps
module csym_link_test;
  localparam int DW = 32, SW = 16, NCLS = 3, CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic hold_mode, pkt_valid, pkt_sop, pkt_eop, pkt_ready;
  logic [DW-1:0] pkt_data;
  logic [NCLS-1:0] sym_valid, sym_ready;
  logic [NCLS-1:0][SW-1:0] sym_data;
  logic link_valid, link_tag, link_sop, link_eop;
  logic [DW-1:0] link_data;
  logic rx_pkt_valid, rx_pkt_sop, rx_pkt_eop, rx_sym_valid;
  logic [DW-1:0] rx_pkt_data;
  logic [CW-1:0] rx_sym_cls;
  logic [SW-1:0] rx_sym_data;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  logic last_pr;
  logic [NCLS-1:0] last_sr;
  logic [DW+1:0]    exp_pkt[$], got_pkt[$];
  logic [CW+SW-1:0] exp_sym[$], got_sym[$];

  always #2 clk = ~clk;

  csym_link uut (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
    .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .pkt_data(pkt_data), .pkt_ready(pkt_ready),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_ready(sym_ready),
    .link_valid(link_valid), .link_tag(link_tag), .link_sop(link_sop),
    .link_eop(link_eop), .link_data(link_data),
    .rx_valid(link_valid), .rx_tag(link_tag), .rx_sop(link_sop),
    .rx_eop(link_eop), .rx_data(link_data),
    .rx_pkt_valid(rx_pkt_valid), .rx_pkt_sop(rx_pkt_sop),
    .rx_pkt_eop(rx_pkt_eop), .rx_pkt_data(rx_pkt_data),
    .rx_sym_valid(rx_sym_valid), .rx_sym_cls(rx_sym_cls),
    .rx_sym_data(rx_sym_data)
  );

  // receive monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_pkt_valid) got_pkt.push_back({rx_pkt_sop, rx_pkt_eop, rx_pkt_data});
      if (rx_sym_valid) got_sym.push_back({rx_sym_cls, rx_sym_data});
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, note handshakes, return at next negedge
  task automatic cyc(input logic pv, input logic ps, input logic pe,
                     input logic [DW-1:0] pd, input logic [NCLS-1:0] sv,
                     input logic [SW-1:0] s0, input logic [SW-1:0] s1,
                     input logic [SW-1:0] s2);
    pkt_valid = pv; pkt_sop = ps; pkt_eop = pe; pkt_data = pd;
    sym_valid = sv; sym_data[0] = s0; sym_data[1] = s1; sym_data[2] = s2;
    #1;
    last_pr = pkt_ready;
    last_sr = sym_ready;
    if (pv && pkt_ready) exp_pkt.push_back({ps, pe, pd});
    for (int i = 0; i < NCLS; i++)
      if (sv[i] && sym_ready[i]) exp_sym.push_back({CW'(i), sym_data[i]});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, '0, '0, '0, '0, '0);
  endtask

  task automatic chk_pkt_word(input string req, input logic s, input logic e,
                              input logic [DW-1:0] d);
    chk(link_valid && !link_tag && link_sop == s && link_eop == e && link_data == d,
        req, "link packet word", {link_valid, link_tag, link_sop, link_eop, link_data},
        {1'b1, 1'b0, s, e, d});
  endtask

  task automatic chk_sym_word(input string req, input logic [CW-1:0] c,
                              input logic [SW-1:0] p);
    logic [DW-1:0] w;
    w = '0; w[SW+CW-1:0] = {c, p};
    chk(link_valid && link_tag && link_data == w, req, "link symbol word",
        {link_valid, link_tag, link_data}, {1'b1, 1'b1, w});
  endtask

  // end-to-end comparison of reassembled stream and symbols (R9, R10)
  task automatic e2e();
    idle(3);
    chk(got_pkt.size() == exp_pkt.size(), "R10", "packet word count",
        got_pkt.size(), exp_pkt.size());
    for (int i = 0; i < exp_pkt.size() && i < got_pkt.size(); i++)
      if (got_pkt[i] != exp_pkt[i]) begin
        chk(0, "R10", "reassembled word", got_pkt[i], exp_pkt[i]);
        break;
      end
    chk(got_sym.size() == exp_sym.size(), "R9", "symbol count",
        got_sym.size(), exp_sym.size());
    for (int i = 0; i < exp_sym.size() && i < got_sym.size(); i++)
      if (got_sym[i] != exp_sym[i]) begin
        chk(0, "R9", "extracted symbol", got_sym[i], exp_sym[i]);
        break;
      end
    exp_pkt.delete(); got_pkt.delete(); exp_sym.delete(); got_sym.delete();
  endtask

  task automatic t_reset();  // R1
    rst_n = 1'b0; hold_mode = 1'b0;
    pkt_valid = 0; pkt_sop = 0; pkt_eop = 0; pkt_data = '0;
    sym_valid = '0; sym_data = '0;
    repeat (3) @(negedge clk);
    chk(!link_valid && !rx_pkt_valid && !rx_sym_valid && pkt_ready, "R1",
        "outputs in reset", {link_valid, rx_pkt_valid, rx_sym_valid, pkt_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!link_valid && !rx_pkt_valid && !rx_sym_valid && pkt_ready, "R1",
        "outputs after release", {link_valid, rx_pkt_valid, rx_sym_valid, pkt_ready}, 4'b0001);
  endtask

  task automatic t_pass();  // R2
    cyc(1, 1, 0, 32'hA000_0001, '0, '0, '0, '0);
    chk(last_pr, "R2", "ready on start word", last_pr, 1);
    chk_pkt_word("R2", 1, 0, 32'hA000_0001);
    cyc(1, 0, 0, 32'hA000_0002, '0, '0, '0, '0);
    chk_pkt_word("R2", 0, 0, 32'hA000_0002);
    cyc(1, 0, 1, 32'hA000_0003, '0, '0, '0, '0);
    chk_pkt_word("R2", 0, 1, 32'hA000_0003);
    e2e();
  endtask

  task automatic t_sym1();  // R3, R9
    cyc(0, 0, 0, '0, 3'b100, '0, '0, 16'h5A5A);
    chk(last_sr == 3'b100, "R3", "sym_ready same cycle", last_sr, 3'b100);
    chk_sym_word("R3", 2'd2, 16'h5A5A);
    cyc(0, 0, 0, '0, '0, '0, '0, '0);
    chk(!link_valid, "R3", "link idle after symbol", link_valid, 0);
    chk(rx_sym_valid && !rx_pkt_valid && rx_sym_cls == 2'd2 && rx_sym_data == 16'h5A5A,
        "R9", "extracted next cycle", {rx_sym_valid, rx_pkt_valid, rx_sym_cls, rx_sym_data},
        {1'b1, 1'b0, 2'd2, 16'h5A5A});
    e2e();
  endtask

  task automatic t_prio();  // R4
    cyc(0, 0, 0, '0, 3'b111, 16'h0011, 16'h0022, 16'h0033);
    chk(last_sr == 3'b001, "R4", "first grant event", last_sr, 3'b001);
    chk_sym_word("R4", 2'd0, 16'h0011);
    cyc(0, 0, 0, '0, 3'b110, 16'h0011, 16'h0022, 16'h0033);
    chk(last_sr == 3'b010, "R4", "second grant buffer status", last_sr, 3'b010);
    chk_sym_word("R4", 2'd1, 16'h0022);
    cyc(0, 0, 0, '0, 3'b100, 16'h0011, 16'h0022, 16'h0033);
    chk(last_sr == 3'b100, "R4", "third grant congestion", last_sr, 3'b100);
    chk_sym_word("R4", 2'd2, 16'h0033);
    e2e();
  endtask

  task automatic t_mid();  // R5
    cyc(1, 1, 0, 32'hB000_0000, '0, '0, '0, '0);
    chk_pkt_word("R5", 1, 0, 32'hB000_0000);
    cyc(1, 0, 0, 32'hB000_0001, 3'b010, '0, 16'h0077, '0);
    chk(!last_pr && last_sr == 3'b010, "R5", "stall for inserted symbol",
        {last_pr, last_sr}, {1'b0, 3'b010});
    chk_sym_word("R5", 2'd1, 16'h0077);
    cyc(1, 0, 0, 32'hB000_0001, '0, '0, '0, '0);
    chk(last_pr, "R5", "ready back after one cycle", last_pr, 1);
    chk_pkt_word("R5", 0, 0, 32'hB000_0001);
    cyc(1, 0, 1, 32'hB000_0002, '0, '0, '0, '0);
    chk_pkt_word("R5", 0, 1, 32'hB000_0002);
    e2e();
  endtask

  task automatic t_b2b();  // R6
    cyc(1, 1, 0, 32'hC000_0000, '0, '0, '0, '0);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0, 32'hC000_0001, 3'b001, 16'(16'hE0 + k), '0, '0);
      chk(!last_pr && last_sr == 3'b001, "R6", "burst stall",
          {last_pr, last_sr}, {1'b0, 3'b001});
      chk_sym_word("R6", 2'd0, 16'(16'hE0 + k));
    end
    cyc(1, 0, 0, 32'hC000_0001, '0, '0, '0, '0);
    chk_pkt_word("R6", 0, 0, 32'hC000_0001);
    cyc(1, 0, 1, 32'hC000_0002, '0, '0, '0, '0);
    chk_pkt_word("R6", 0, 1, 32'hC000_0002);
    e2e();
  endtask

  task automatic t_hold();  // R7
    hold_mode = 1'b1;
    cyc(1, 1, 0, 32'hD000_0000, '0, '0, '0, '0);
    cyc(1, 0, 0, 32'hD000_0001, 3'b001, 16'h00E1, '0, '0);
    chk(last_pr && last_sr == 3'b000, "R7", "symbol held mid-packet",
        {last_pr, last_sr}, {1'b1, 3'b000});
    chk_pkt_word("R7", 0, 0, 32'hD000_0001);
    cyc(1, 0, 1, 32'hD000_0002, 3'b001, 16'h00E1, '0, '0);
    chk(last_pr && last_sr == 3'b000, "R7", "symbol held on end word",
        {last_pr, last_sr}, {1'b1, 3'b000});
    chk_pkt_word("R7", 0, 1, 32'hD000_0002);
    cyc(0, 0, 0, '0, 3'b001, 16'h00E1, '0, '0);
    chk(last_sr == 3'b001, "R7", "released after end word", last_sr, 3'b001);
    chk_sym_word("R7", 2'd0, 16'h00E1);
    e2e();
  endtask

  task automatic t_hold_idle();  // R8
    cyc(1, 1, 0, 32'hF000_0000, 3'b100, '0, '0, 16'h0C0C);
    chk(!last_pr && last_sr == 3'b100, "R8", "symbol beats start word",
        {last_pr, last_sr}, {1'b0, 3'b100});
    chk_sym_word("R8", 2'd2, 16'h0C0C);
    cyc(1, 1, 1, 32'hF000_0000, '0, '0, '0, '0);
    chk_pkt_word("R8", 1, 1, 32'hF000_0000);
    hold_mode = 1'b0;
    e2e();
  endtask

  initial begin
    t_reset();
    t_pass();
    t_sym1();
    t_prio();
    t_mid();
    t_b2b();
    t_hold();
    t_hold_idle();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule